// File: doc/BRIEF.md
# Reload-Match Counter PWM Generator

This block produces a pulse-width-modulated output from a free-running up-counter. The counter tops out at its all-ones value and is reloaded from a load register. A second register, the match value, marks where the active phase ends. Software-side logic supplies a period and a duty, both already expressed in functional-clock cycles. The block checks and clamps these values, then derives the load and match values itself. As a result, each period sits at the top of the counter range.

The active phase starts when the counter is reloaded and lasts through the cycle in which the counter equals the match value. The inactive phase then runs until the counter overflows. The derived values always keep one cycle or more between load and match, and between match and overflow. An accepted configuration is held in shadow registers. It is copied into the running registers only at the next overflow, so a period in flight always completes unchanged. A period below two cycles is refused with an error flag, and the running configuration is kept.

Top module: `pwm_reload_gen`

## Requirements
- R1: After reset `pwmOut` and `cfgError` are 0, and the counter stays stopped with `pwmOut` low until a valid configuration is applied.
- R2: An apply with `cfgPeriod` below 2 sets `cfgError` to 1 in the cycle after the apply. The running (or stopped) output pattern is left unchanged.
- R3: An apply with `cfgPeriod` of 2 or more clears `cfgError` in the cycle after the apply. `cfgError` keeps its value while `cfgApply` is low.
- R4: A `cfgDuty` of 0 is treated as a duty of 1 cycle.
- R5: A `cfgDuty` equal to or above `cfgPeriod` is treated as `cfgPeriod` minus 1.
- R6: The load value is (all-ones − period) + 1 and the match value is load + duty − 1. The running values always satisfy load ≤ match < all-ones.
- R7: Each period has `pwmOut` high for exactly duty cycles, covering counter values load through match. It then has `pwmOut` low for exactly (all-ones − match) = period − duty cycles.
- R8: An accepted configuration applied while running takes effect only at the next overflow. The period in progress finishes with the old values.
- R9: From the stopped state, if an accepted apply is sampled on clock edge E, then `pwmOut` rises on edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPeriod | input | CNT_W | Requested period in clock cycles |
| cfgDuty | input | CNT_W | Requested active time in clock cycles |
| cfgApply | input | 1 | One-cycle strobe that submits period and duty |
| cfgError | output | 1 | High after the most recent apply was refused |
| pwmOut | output | 1 | PWM output, high during the active phase |

## Verification
The bound checker checks the following on every cycle:
- the error flag's response to each apply, and that it holds between applies;
- the ordering invariant between the running load and match values;
- that an overflow always drives the output high on the next edge;
- that a match always drives the output low on the next edge;
- that the output stays low while the counter is stopped.

The high and low lengths that follow from the clamp rules can only be shown by the bench's scenarios, because they are measured over whole periods. The same applies to the deferral of a new configuration until the old period completes, to the start-up latency, and to a refused request leaving the old waveform intact.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic start;  // first commit from the stopped state
    logic swap;   // commit shadow values at an overflow
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgDuty,
  input  logic             cfgApply,
  input  logic             running,
  input  logic             atMax,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] shadowLoad,
  output logic [CNT_W-1:0] shadowMatch,
  output logic             cfgError
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TWO  = {{(CNT_W-2){1'b0}}, 2'b10};

  logic             periodOk;
  logic [CNT_W-1:0] dutyEff;
  logic [CNT_W-1:0] loadCalc;
  logic [CNT_W-1:0] matchCalc;
  logic             pending;

  always_comb begin
    periodOk = (cfgPeriod >= TWO);
    if (cfgDuty == '0)
      dutyEff = ONE;
    else if (cfgDuty >= cfgPeriod)
      dutyEff = cfgPeriod - ONE;
    else
      dutyEff = cfgDuty;
    loadCalc  = (MAXV - cfgPeriod) + ONE;
    matchCalc = loadCalc + dutyEff - ONE;
  end

  always_comb begin
    strobe.start = pending && !running;
    strobe.swap  = pending && running && atMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      shadowLoad  <= '0;
      shadowMatch <= '0;
      cfgError    <= 1'b0;
    end else begin
      if (cfgApply) begin
        cfgError <= !periodOk;
        if (periodOk) begin
          shadowLoad  <= loadCalc;
          shadowMatch <= matchCalc;
          pending     <= 1'b1;
        end else if (strobe.start || strobe.swap) begin
          pending <= 1'b0;
        end
      end else if (strobe.start || strobe.swap) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] shadowLoad,
  input  logic [CNT_W-1:0] shadowMatch,
  output logic             running,
  output logic             atMax,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] activeLoad,
  output logic [CNT_W-1:0] activeMatch,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  assign atMax = (count == MAXV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      activeLoad  <= '0;
      activeMatch <= '0;
      running     <= 1'b0;
      pwmOut      <= 1'b0;
    end else if (strobe.start) begin
      count       <= shadowLoad;
      activeLoad  <= shadowLoad;
      activeMatch <= shadowMatch;
      running     <= 1'b1;
      pwmOut      <= 1'b1;
    end else if (running) begin
      if (atMax) begin
        pwmOut <= 1'b1;
        if (strobe.swap) begin
          count       <= shadowLoad;
          activeLoad  <= shadowLoad;
          activeMatch <= shadowMatch;
        end else begin
          count <= activeLoad;
        end
      end else begin
        count <= count + ONE;
        if (count == activeMatch) pwmOut <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgDuty,
  input  logic             cfgApply,
  output logic             cfgError,
  output logic             pwmOut
);
  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] shadowLoad, shadowMatch;
  logic [CNT_W-1:0] count, activeLoad, activeMatch;
  logic             running, atMax;

  pwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgDuty(cfgDuty),
    .cfgApply(cfgApply), .running(running), .atMax(atMax), .strobe(strobe),
    .shadowLoad(shadowLoad), .shadowMatch(shadowMatch), .cfgError(cfgError)
  );

  pwm_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shadowLoad(shadowLoad),
    .shadowMatch(shadowMatch), .running(running), .atMax(atMax), .count(count),
    .activeLoad(activeLoad), .activeMatch(activeMatch), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_reload_gen_chk.sv
module pwm_reload_gen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cfgPeriod,
  input logic             cfgApply,
  input logic             cfgError,
  input logic             pwmOut,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] activeLoad,
  input logic [CNT_W-1:0] activeMatch
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TWO  = {{(CNT_W-2){1'b0}}, 2'b10};

  // R2
  bad_period_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgApply && cfgPeriod < TWO) |=> cfgError);

  // R3
  good_period_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgApply && cfgPeriod >= TWO) |=> !cfgError);

  // R3
  error_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgApply |=> $stable(cfgError));

  // R6
  load_match_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (activeLoad <= activeMatch && activeMatch != MAXV));

  // R7
  overflow_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && count == MAXV) |=> pwmOut);

  // R7
  match_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && count == activeMatch && count != MAXV) |=> !pwmOut);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !pwmOut);
endmodule

bind pwm_reload_gen pwm_reload_gen_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgApply(cfgApply),
  .cfgError(cfgError), .pwmOut(pwmOut), .running(running), .count(count),
  .activeLoad(activeLoad), .activeMatch(activeMatch)
);

// File: tb/sim_pwm_reload_gen.sv
module sim_pwm_reload_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgPeriod = '0;
  logic [31:0] cfgDuty = '0;
  logic        cfgApply = 1'b0;
  logic        cfgError;
  logic        pwmOut;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  pwm_reload_gen #(.CNT_W(32)) u0 (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .cfgDuty(cfgDuty),
    .cfgApply(cfgApply), .cfgError(cfgError), .pwmOut(pwmOut)
  );

  localparam int NV = 9;
  // period, duty, expected error, expected high cycles, expected low cycles
  localparam logic [31:0] VP [NV] = '{10, 1, 5, 0, 6, 6, 2, 2, 7};
  localparam logic [31:0] VD [NV] = '{ 3, 1, 0, 3, 6, 9, 1, 0, 4};
  localparam logic        VE [NV] = '{ 0, 1, 0, 1, 0, 0, 0, 0, 0};
  localparam int          VH [NV] = '{ 3, 3, 1, 1, 5, 5, 1, 1, 4};
  localparam int          VL [NV] = '{ 7, 7, 4, 4, 1, 1, 1, 1, 3};
  localparam string       VR [NV] = '{"R7", "R2", "R4", "R2", "R5", "R5", "R7", "R4", "R7"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitRise();
    logic p;
    p = pwmOut;
    forever begin
      @(negedge clk);
      if (!p && pwmOut) break;
      p = pwmOut;
    end
  endtask

  // called at a rise; counts one full high then low phase
  task automatic measure(output int h, output int l);
    h = 0;
    l = 0;
    while (pwmOut) begin
      h++;
      @(negedge clk);
      cfgApply = 1'b0;
    end
    while (!pwmOut) begin
      l++;
      @(negedge clk);
    end
  endtask

  task automatic applyCfg(input logic [31:0] p, input logic [31:0] d);
    cfgPeriod = p;
    cfgDuty   = d;
    cfgApply  = 1'b1;
    @(negedge clk);
    cfgApply  = 1'b0;
  endtask

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b0, "R1", pwmOut, 0);
    check(cfgError == 1'b0, "R1", cfgError, 0);
    begin
      int highs = 0;
      repeat (20) begin @(negedge clk); if (pwmOut) highs++; end
      check(highs == 0, "R1", highs, 0);
    end
    // refused request while stopped: flag set, output stays low
    applyCfg(32'd1, 32'd1);
    check(cfgError == 1'b1, "R2", cfgError, 1);
    begin
      int highs = 0;
      repeat (20) begin @(negedge clk); if (pwmOut) highs++; end
      check(highs == 0, "R2", highs, 0);
    end
    // first start latency: R9
    cfgPeriod = 32'd4;
    cfgDuty   = 32'd2;
    cfgApply  = 1'b1;
    @(negedge clk);
    cfgApply  = 1'b0;
    check(pwmOut == 1'b0, "R9", pwmOut, 0);
    check(cfgError == 1'b0, "R3", cfgError, 0);
    @(negedge clk);
    check(pwmOut == 1'b1, "R9", pwmOut, 1);
    measure(h, l);
    check(h == 2, "R7", h, 2);
    check(l == 2, "R7", l, 2);

    // vector table
    for (int i = 0; i < NV; i++) begin
      applyCfg(VP[i], VD[i]);
      check(cfgError == VE[i], VE[i] ? "R2" : "R3", cfgError, VE[i]);
      waitRise();
      waitRise();
      measure(h, l);
      check(h == VH[i], VR[i], h, VH[i]);
      check(l == VL[i], VR[i], l, VL[i]);
    end

    // R8: apply at a rise while running 7/4; current period stays old
    cfgPeriod = 32'd12;
    cfgDuty   = 32'd9;
    cfgApply  = 1'b1;
    measure(h, l);
    check(h == 4, "R8", h, 4);
    check(l == 3, "R8", l, 3);
    measure(h, l);
    check(h == 9, "R8", h, 9);
    check(l == 3, "R8", l, 3);
    // R3: flag holds with no apply
    check(cfgError == 1'b0, "R3", cfgError, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule